// File: doc/BRIEF.md
# I2C Bus-Recovery Sequencer

This block is a master-side engine that frees a two-wire bus left stuck by a slave that keeps the data line low. It is triggered by a single-cycle request. It first lets both lines float for one half-period and reads them back. If data reads low, it drives clock pulses with its own data driver released. After each pulse it samples data at the end of the clock-high phase. As soon as data reads high, it re-qualifies the idle bus. It then issues a Start, which pulls data low while clock is high, followed directly by a Stop, which releases data while clock is high. This returns every slave's interface to its idle state.

Both lines are open-drain: the block only asserts a pull-low enable per line and observes the real levels through synchronized readback inputs. The number of clock pulses is bounded. A watchdog catches a clock line that another device holds low. Either way, the block finishes with a one-cycle done pulse and a pass/fail status, and it leaves both lines released.

Top module: `busfree_seq`

## Requirements
- R1: After reset, both pull-low enables (`scl_oe`, `sda_oe`) are 0 and `done_o` is 0.
- R2: If both lines read high at the request, no clock pulse is issued. The block makes a Start and then a Stop, and `done_o` rises with `ok_o`=1 exactly 3*HALF_CYC clocks after the clock edge that accepted the request.
- R3: `sda_oe` changes only while the block releases SCL. It rises (Start) only after SCL and SDA both read high for the preceding half-period. It falls (Stop) one half-period later, while SCL is still released.
- R4: During clocking, SDA is released. SCL is pulled low for HALF_CYC clocks, then released. The high phase lasts HALF_CYC clocks counted from the moment SCL reads high, which is SYNC_STAGES clocks after release. SDA is sampled at its end.
- R5: A slave that frees SDA after K clock falls (1 <= K <= MAX_PULSES) gets exactly K pulses. It is followed by one Start and one Stop, and done with `ok_o`=1 at 4*HALF_CYC + K*(2*HALF_CYC+SYNC_STAGES) clocks.
- R6: If SDA still reads low after MAX_PULSES pulses, the block stops at once. It makes no Start or Stop and reports done with `ok_o`=0 at HALF_CYC + MAX_PULSES*(2*HALF_CYC+SYNC_STAGES) clocks.
- R7: If SCL reads low for WD_CYC consecutive clocks while the block releases it, the block reports done with `ok_o`=0. For a clock held before the request, this happens WD_CYC clocks after acceptance.
- R8: `done_o` is high for exactly one clock. `ok_o` holds its value until the next completion. Both lines are released from the cycle after done onward.
- R9: A request while a recovery is running is ignored. It does not change the outcome or the timing, and it does not cause a second done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Recovery request, sampled in idle only |
| scl_in | input | 1 | Clock line level read back from the bus |
| sda_in | input | 1 | Data line level read back from the bus |
| scl_oe | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | 1 if the bus was freed; valid with and after `done_o` |

## Verification
Every result is due at an exact clock count after the edge that accepts the request. A clean bus takes 3*HALF_CYC. A bus freed after K falls takes 4*HALF_CYC + K*(2*HALF_CYC+2). A bus still stuck after nine pulses takes HALF_CYC + 9*(2*HALF_CYC+2). A held clock takes WD_CYC. The bench counts rising edges from acceptance, samples `done_o` at each falling edge, and compares the count against these formulas for K from 0 to 11. At the same falling edge, it reads the status and its tallies of line falls, Starts and Stops seen on the modelled open-drain wires. One falling edge later it checks that done has dropped and that both lines are released.

// File: rtl/busfree_pkg.sv
package busfree_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_LOW   = 3'd2,
        ST_HIGH  = 3'd3,
        ST_START = 3'd4,
        ST_STOP  = 3'd5
    } rec_state_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } line_drive_t;

    localparam int DEF_MAX_PULSES = 9;

    // Pull-low enables that each state applies to the bus.
    function automatic line_drive_t drive_for(rec_state_e s);
        line_drive_t d;
        d.scl_low = (s == ST_LOW);
        d.sda_low = (s == ST_START);
        return d;
    endfunction

    // States in which the clock line is left floating and must read high.
    function automatic logic clock_released(rec_state_e s);
        return (s == ST_CHECK) || (s == ST_HIGH) ||
               (s == ST_START) || (s == ST_STOP);
    endfunction

endpackage

// File: rtl/busfree_sync.sv
module busfree_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic r;
            always_ff @(posedge clk) begin
                if (rst) r <= RST_VAL;
                else     r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
            assign q = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/busfree_tick.sv
module busfree_tick #(
    parameter int HALF_CYC = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 2;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr || tick || !run) cnt <= '0;
        else                            cnt <= cnt + CW'(1);
    end

    a_r4_tick_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
endmodule

// File: rtl/busfree_wdog.sv
module busfree_wdog #(
    parameter int WD_CYC = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic expire
);
    localparam int WW = $clog2(WD_CYC + 1);
    localparam logic [WW-1:0] LAST = WW'(WD_CYC - 1);

    logic [WW-1:0] cnt;

    assign expire = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr || !run || expire) cnt <= '0;
        else                              cnt <= cnt + WW'(1);
    end

    a_r7_wd_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
endmodule

// File: rtl/busfree_seq.sv
module busfree_seq
    import busfree_pkg::*;
#(
    parameter int HALF_CYC    = 250,
    parameter int WD_CYC      = 100000,
    parameter int MAX_PULSES  = DEF_MAX_PULSES,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_oe,
    output logic sda_oe,
    output logic done_o,
    output logic ok_o
);
    localparam int PW = $clog2(MAX_PULSES + 1);
    localparam logic [PW-1:0] PMAX  = PW'(MAX_PULSES);
    localparam logic [PW-1:0] PLAST = PW'(MAX_PULSES - 1);

    rec_state_e  state_q, state_d;
    logic [PW-1:0] pulse_q, pulse_d;
    logic        done_q, done_d, ok_q, ok_d;
    logic        scl_s, sda_s;
    logic        tick, wd_exp, released, tick_run, wd_run, clr;
    line_drive_t drv;

    busfree_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
        .clk(clk), .rst(rst), .d(scl_in), .q(scl_s));
    busfree_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
        .clk(clk), .rst(rst), .d(sda_in), .q(sda_s));

    assign released = clock_released(state_q);
    assign tick_run = (state_q == ST_LOW) ? 1'b1 : (released && scl_s);
    assign wd_run   = released && !scl_s;
    assign clr      = (state_d != state_q) || (state_q == ST_IDLE);

    busfree_tick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk(clk), .rst(rst), .clr(clr), .run(tick_run), .tick(tick));
    busfree_wdog #(.WD_CYC(WD_CYC)) u_wdog (
        .clk(clk), .rst(rst), .clr(clr), .run(wd_run), .expire(wd_exp));

    always_comb begin
        state_d = state_q;
        pulse_d = pulse_q;
        done_d  = 1'b0;
        ok_d    = ok_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_CHECK;
                    pulse_d = '0;
                end
            end
            ST_CHECK: begin
                if (wd_exp) begin
                    state_d = ST_IDLE; done_d = 1'b1; ok_d = 1'b0;
                end else if (tick) begin
                    if (sda_s)                state_d = ST_START;
                    else if (pulse_q == PMAX) begin
                        state_d = ST_IDLE; done_d = 1'b1; ok_d = 1'b0;
                    end else                  state_d = ST_LOW;
                end
            end
            ST_LOW: begin
                if (tick) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (wd_exp) begin
                    state_d = ST_IDLE; done_d = 1'b1; ok_d = 1'b0;
                end else if (tick) begin
                    pulse_d = pulse_q + PW'(1);
                    if (sda_s)                 state_d = ST_CHECK;
                    else if (pulse_q == PLAST) begin
                        state_d = ST_IDLE; done_d = 1'b1; ok_d = 1'b0;
                    end else                   state_d = ST_LOW;
                end
            end
            ST_START: begin
                if (wd_exp) begin
                    state_d = ST_IDLE; done_d = 1'b1; ok_d = 1'b0;
                end else if (tick) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (wd_exp) begin
                    state_d = ST_IDLE; done_d = 1'b1; ok_d = 1'b0;
                end else if (tick) begin
                    state_d = ST_IDLE; done_d = 1'b1; ok_d = sda_s;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pulse_q <= '0;
            done_q  <= 1'b0;
            ok_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            pulse_q <= pulse_d;
            done_q  <= done_d;
            ok_q    <= ok_d;
        end
    end

    assign drv    = drive_for(state_q);
    assign scl_oe = drv.scl_low;
    assign sda_oe = drv.sda_low;
    assign done_o = done_q;
    assign ok_o   = ok_q;

    // R8: completion pulse lasts one cycle and leaves the bus released
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    a_r8_released_after: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!scl_oe && !sda_oe));
    // R3: data driver moves only with the clock released; Start needs an idle bus
    a_r3_sda_moves_scl_free: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> (!scl_oe && !$past(scl_oe)));
    a_r3_start_on_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(scl_s && sda_s));
    // R4: data stays released whenever the clock is pulled low
    a_r4_sda_free_clocking: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_oe) |-> !sda_oe);
    // R6: pulse count never exceeds its bound
    a_r6_pulse_bound: assert property (@(posedge clk) disable iff (rst)
        pulse_q <= PMAX);
    // R7: watchdog expiry ends the run as a failure
    a_r7_wd_fails: assert property (@(posedge clk) disable iff (rst)
        wd_exp |=> (done_o && !ok_o));
    // R9: requests during a run do not restart it
    a_r9_busy_ignored: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && start_i && !done_d) |=> (state_q != ST_IDLE));
endmodule

// File: tb/busfree_seq_test.sv
module busfree_seq_test;
    localparam int H  = 4;
    localparam int W  = 40;
    localparam int MP = 9;
    localparam int SS = 2;

    logic clk = 1'b0;
    logic rst;
    logic start_i;
    logic scl_hold;
    logic scl_oe, sda_oe, done_o, ok_o;
    logic scl_line, sda_line;
    int   fall_cnt = 0;
    int   stuck_until = 0;
    int   starts = 0;
    int   stops = 0;
    int   vectors = 0;
    int   errors = 0;

    always #4 clk = ~clk;

    assign scl_line = !(scl_oe || scl_hold);
    assign sda_line = !(sda_oe || (fall_cnt < stuck_until));

    always @(negedge scl_line) fall_cnt <= fall_cnt + 1;
    always @(negedge sda_line) if (scl_line === 1'b1) starts = starts + 1;
    always @(posedge sda_line) if (scl_line === 1'b1) stops = stops + 1;

    busfree_seq #(.HALF_CYC(H), .WD_CYC(W), .MAX_PULSES(MP), .SYNC_STAGES(SS)) uut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .scl_in(scl_line), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .done_o(done_o), .ok_o(ok_o));

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_cycles(input int k);
        if (k == 0)  return 3 * H;
        if (k <= MP) return 4 * H + k * (2 * H + SS);
        return H + MP * (2 * H + SS);
    endfunction

    task automatic run_case(input int k, input bit poke, input string req);
        int n, f0, s0, p0, extra;
        bit seen, ok_exp;
        @(negedge clk);
        stuck_until = fall_cnt + k;
        @(negedge clk);
        f0 = fall_cnt; s0 = starts; p0 = stops;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        n = 0; seen = 1'b0;
        while (n < 2000 && !seen) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start_i = (poke && (n == H + 5 || n == 3 * H + 1)) ? 1'b1 : 1'b0;
            if (done_o) seen = 1'b1;
        end
        start_i = 1'b0;
        ok_exp = (k <= MP);
        chk(req, "done seen", int'(seen), 1);
        chk(req, "cycles to done", n, exp_cycles(k));
        chk(req, "ok status", int'(ok_o), int'(ok_exp));
        chk(req, "clock falls", fall_cnt - f0, (k > MP) ? MP : k);
        chk("R3", "starts", starts - s0, ok_exp ? 1 : 0);
        chk("R3", "stops", stops - p0, ok_exp ? 1 : 0);
        @(negedge clk);
        chk("R8", "done width", int'(done_o), 0);
        chk("R8", "lines released", int'(scl_oe || sda_oe), 0);
        stuck_until = fall_cnt;
        extra = 0;
        for (int i = 0; i < 3 * exp_cycles(k); i++) begin
            @(negedge clk);
            if (done_o) extra++;
        end
        chk(poke ? "R9" : "R8", "extra done pulses", extra, 0);
        chk("R8", "ok held", int'(ok_o), int'(ok_exp));
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start_i = 1'b0; scl_hold = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "scl_oe after reset", int'(scl_oe), 0);
        chk("R1", "sda_oe after reset", int'(sda_oe), 0);
        chk("R1", "done after reset", int'(done_o), 0);

        // R2 clean bus; R5 freed after K falls; R6 never freed within the bound
        for (int k = 0; k <= MP + 2; k++) begin
            if (k == 0)       run_case(k, 1'b0, "R2");
            else if (k <= MP) run_case(k, 1'b0, "R5");
            else              run_case(k, 1'b0, "R6");
        end

        // R4 pulse timing is folded into the cycle counts above; R9 busy requests
        run_case(3, 1'b1, "R9");
        run_case(MP + 5, 1'b1, "R9");

        // R7 clock held low by another device
        begin
            int n, s0, p0;
            bit seen;
            @(negedge clk);
            scl_hold = 1'b1;
            repeat (6) @(negedge clk);
            s0 = starts; p0 = stops;
            start_i = 1'b1;
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
            n = 0; seen = 1'b0;
            while (n < 2000 && !seen) begin
                @(posedge clk);
                n++;
                @(negedge clk);
                if (done_o) seen = 1'b1;
            end
            chk("R7", "done seen", int'(seen), 1);
            chk("R7", "cycles to done", n, W);
            chk("R7", "ok status", int'(ok_o), 0);
            chk("R7", "no start", starts - s0, 0);
            chk("R7", "no stop", stops - p0, 0);
            @(negedge clk);
            chk("R7", "lines released", int'(scl_oe || sda_oe), 0);
            scl_hold = 1'b0;
            repeat (10) @(negedge clk);
        end

        // recovery after a failure: clean bus succeeds again
        run_case(0, 1'b0, "R2");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule